// File: doc/BRIEF.md
# Over-Range Flag Generator

This block monitors a stream of signed converter samples, one per frame clock, and raises a single over-range flag whenever a sample's magnitude is larger than a programmable threshold. The flag appears a fixed eight cycles after the offending sample. Its release can be delayed by a programmable hold of 0 to 15 extra cycles, so that a one-sample excursion stays visible long enough for slow logic to catch it.

The threshold, the hold count and an enable come from configuration registers and are plain inputs here. The flag is available on its own output. It is also steered onto a shared output pin. A mode input on that pin picks either the flag or the serial-interface read data that shares it.

The sample input carries a valid strobe and has no back-pressure. The block takes one sample per cycle and never stalls, so it has no ready signal. A cycle with the strobe low carries no sample and counts as in range.

Top module: `ovr_flag_gen`

## Requirements
- R1: A valid sample counts as over range when the absolute value of its two's-complement value is strictly greater than `ovr_thr`, read as an unsigned number. A sample whose magnitude equals the threshold is in range. The most negative code has magnitude 2^(SAMPLE_W-1).
- R2: Suppose an over-range sample is presented in cycle c, and enable was high from c through c+8. Then `ovr_flag` is high in cycle c+8 and low in cycle c+7, if no earlier sample caused it.
- R3: Let `ovr_hold` be H, from 0 to 15. Let c be the last over-range sample of an excursion, so the first in-range cycle is c+1. Then `ovr_flag` stays high through cycle c+8+H and is low from cycle c+9+H. A lone excursion therefore holds the flag for exactly 1+H cycles.
- R4: An over-range sample that arrives while the flag is being held restarts the hold. The flag stays high without a gap until H cycles after that new sample's own eight-cycle point.
- R5: A cycle with `in_valid` low is treated as in range, whatever value is on `in_data`.
- R6: While `ovr_en` is low, `ovr_flag` is 0 from the next cycle on. Samples already in the delay pipeline are discarded, so they never raise the flag after enable returns.
- R7: A synchronous `rst` clears the flag, the delay pipeline and the hold counter. The flag is 0 in the cycle after the reset edge, and samples taken before the reset never raise it.
- R8: With `pin_mode` = 1, `pin_out` follows `ovr_flag`. With `pin_mode` = 0, it follows `sdo_in`. This path is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock, one sample per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ovr_en | input | 1 | Over-range detection enable |
| in_valid | input | 1 | Sample strobe; there is no back-pressure |
| in_data | input | SAMPLE_W | Signed two's-complement sample |
| ovr_thr | input | SAMPLE_W | Unsigned magnitude threshold |
| ovr_hold | input | HOLD_W | Extra release cycles (0 to 15 by default) |
| pin_mode | input | 1 | Shared pin select: 1 gives the flag, 0 gives serial data |
| sdo_in | input | 1 | Serial-interface read data sharing the pin |
| ovr_flag | output | 1 | Over-range flag |
| pin_out | output | 1 | Shared pin output |

## Verification
The hold-length property assumes that `ovr_hold` and `ovr_thr` stay constant while an excursion is in flight. It assumes that a sample's over-range status is judged against the threshold present in the cycle the sample is taken. The bench changes both settings only after at least thirty quiet cycles, when the pipeline and the hold counter are empty. The enable and reset are toggled only at clock midpoints, so each one takes effect at a well-defined edge.

// File: rtl/ovr_pkg.sv
package ovr_pkg;
  localparam int unsigned DEF_SAMPLE_W = 14;
  localparam int unsigned DEF_LAT      = 8;
  localparam int unsigned DEF_HOLD_W   = 4;

  typedef enum logic {
    PIN_SERIAL = 1'b0,
    PIN_FLAG   = 1'b1
  } pin_sel_e;
endpackage

// File: rtl/ovr_mag_cmp.sv
module ovr_mag_cmp #(
  parameter int unsigned SAMPLE_W = ovr_pkg::DEF_SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic [SAMPLE_W-1:0] thr,
  output logic                over_q
);
  logic [SAMPLE_W-1:0] mag;
  logic                exceed;

  // R1: two's-complement magnitude; the most negative code maps to 2^(W-1)
  always_comb begin
    if (in_data[SAMPLE_W-1]) mag = (~in_data) + 1'b1;
    else                     mag = in_data;
    exceed = in_valid && (mag > thr);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) over_q <= 1'b0;
    else            over_q <= exceed;
  end
endmodule

// File: rtl/ovr_delay_line.sv
module ovr_delay_line #(
  parameter int unsigned DEPTH = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic d_in,
  output logic d_out
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign d_out = d_in;
    end else if (DEPTH == 1) begin : g_one
      logic stage;
      always_ff @(posedge clk) begin
        if (rst || !en) stage <= 1'b0;
        else            stage <= d_in;
      end
      assign d_out = stage;
    end else begin : g_shift
      logic [DEPTH-1:0] stage;
      always_ff @(posedge clk) begin
        if (rst || !en) stage <= '0;
        else            stage <= {stage[DEPTH-2:0], d_in};
      end
      assign d_out = stage[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/ovr_hold_stretch.sv
module ovr_hold_stretch #(
  parameter int unsigned HOLD_W = ovr_pkg::DEF_HOLD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              d_over,
  input  logic [HOLD_W-1:0] hold,
  output logic              flag
);
  logic [HOLD_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      flag <= 1'b0;
      cnt  <= '0;
    end else if (d_over) begin
      flag <= 1'b1;
      cnt  <= hold;
    end else if (cnt != '0) begin
      cnt  <= cnt - 1'b1;
    end else begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/ovr_pin_mux.sv
module ovr_pin_mux (
  input  logic pin_mode,
  input  logic flag,
  input  logic sdo_in,
  output logic pin_out
);
  ovr_pkg::pin_sel_e sel;

  always_comb begin
    sel = ovr_pkg::pin_sel_e'(pin_mode);
    unique case (sel)
      ovr_pkg::PIN_FLAG:   pin_out = flag;
      ovr_pkg::PIN_SERIAL: pin_out = sdo_in;
      default:             pin_out = sdo_in;
    endcase
  end
endmodule

// File: rtl/ovr_flag_gen.sv
module ovr_flag_gen #(
  parameter int unsigned SAMPLE_W = ovr_pkg::DEF_SAMPLE_W,
  parameter int unsigned LAT      = ovr_pkg::DEF_LAT,
  parameter int unsigned HOLD_W   = ovr_pkg::DEF_HOLD_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ovr_en,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic [SAMPLE_W-1:0] ovr_thr,
  input  logic [HOLD_W-1:0]   ovr_hold,
  input  logic                pin_mode,
  input  logic                sdo_in,
  output logic                ovr_flag,
  output logic                pin_out
);
  // one register in the comparator, one in the stretcher, the rest in between
  localparam int unsigned DLY_STAGES = LAT - 2;

  logic over_q;
  logic over_late;

  ovr_mag_cmp #(.SAMPLE_W(SAMPLE_W)) u_cmp (
    .clk(clk), .rst(rst), .en(ovr_en),
    .in_valid(in_valid), .in_data(in_data), .thr(ovr_thr),
    .over_q(over_q)
  );

  ovr_delay_line #(.DEPTH(DLY_STAGES)) u_dly (
    .clk(clk), .rst(rst), .en(ovr_en),
    .d_in(over_q), .d_out(over_late)
  );

  ovr_hold_stretch #(.HOLD_W(HOLD_W)) u_hold (
    .clk(clk), .rst(rst), .en(ovr_en),
    .d_over(over_late), .hold(ovr_hold),
    .flag(ovr_flag)
  );

  ovr_pin_mux u_mux (
    .pin_mode(pin_mode), .flag(ovr_flag), .sdo_in(sdo_in),
    .pin_out(pin_out)
  );
endmodule

// File: rtl/ovr_flag_gen_chk.sv
module ovr_flag_gen_chk #(
  parameter int unsigned SAMPLE_W = ovr_pkg::DEF_SAMPLE_W,
  parameter int unsigned LAT      = ovr_pkg::DEF_LAT,
  parameter int unsigned HOLD_W   = ovr_pkg::DEF_HOLD_W
) (
  input logic                clk,
  input logic                rst,
  input logic                ovr_en,
  input logic                in_valid,
  input logic [SAMPLE_W-1:0] in_data,
  input logic [SAMPLE_W-1:0] ovr_thr,
  input logic [HOLD_W-1:0]   ovr_hold,
  input logic                pin_mode,
  input logic                sdo_in,
  input logic                ovr_flag,
  input logic                pin_out
);
  logic [SAMPLE_W-1:0] mag;
  logic                over_now;
  logic [LAT-1:0]      hist;
  logic [HOLD_W:0]     since;

  always_comb begin
    mag      = in_data[SAMPLE_W-1] ? (~in_data) + 1'b1 : in_data;
    over_now = in_valid && (mag > ovr_thr);
  end

  // hist[LAT-1] in cycle c+LAT carries the status of the sample taken in cycle c
  always_ff @(posedge clk) begin
    if (rst || !ovr_en) hist <= '0;
    else                hist <= {hist[LAT-2:0], over_now};
  end

  always_ff @(posedge clk) begin
    if (rst || !ovr_en)       since <= '1;
    else if (hist[LAT-1])     since <= {{HOLD_W{1'b0}}, 1'b1};
    else if (since != '1)     since <= since + 1'b1;
  end

  p_flag_on_over_r2: assert property (@(posedge clk) disable iff (rst)
    hist[LAT-1] |-> ovr_flag);

  p_rise_has_cause_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_flag) |-> hist[LAT-1]);

  p_hold_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (ovr_flag && !hist[LAT-1]) |-> (since <= {1'b0, ovr_hold}));

  p_disable_clears_r6: assert property (@(posedge clk) disable iff (rst)
    !ovr_en |=> !ovr_flag);

  p_reset_clears_r7: assert property (@(posedge clk)
    rst |=> !ovr_flag);

  p_pin_flag_r8: assert property (@(posedge clk) disable iff (rst)
    pin_mode |-> (pin_out == ovr_flag));

  p_pin_serial_r8: assert property (@(posedge clk) disable iff (rst)
    !pin_mode |-> (pin_out == sdo_in));
endmodule

bind ovr_flag_gen ovr_flag_gen_chk #(
  .SAMPLE_W(SAMPLE_W), .LAT(LAT), .HOLD_W(HOLD_W)
) u_chk (
  .clk(clk), .rst(rst), .ovr_en(ovr_en), .in_valid(in_valid),
  .in_data(in_data), .ovr_thr(ovr_thr), .ovr_hold(ovr_hold),
  .pin_mode(pin_mode), .sdo_in(sdo_in), .ovr_flag(ovr_flag),
  .pin_out(pin_out)
);

// File: tb/ovr_flag_gen_test.sv
module ovr_flag_gen_test;
  localparam int SW  = 14;
  localparam int HW  = 4;
  localparam int LAT = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ovr_en = 1'b1;
  logic          in_valid = 1'b0;
  logic [SW-1:0] in_data = '0;
  logic [SW-1:0] ovr_thr = SW'(100);
  logic [HW-1:0] ovr_hold = '0;
  logic          pin_mode = 1'b1;
  logic          sdo_in = 1'b0;
  logic          ovr_flag;
  logic          pin_out;

  int nchk = 0;
  int nfail = 0;
  int smp [0:63];
  bit vld [0:63];
  bit obs [0:127];

  ovr_flag_gen #(.SAMPLE_W(SW), .LAT(LAT), .HOLD_W(HW)) uut (
    .clk(clk), .rst(rst), .ovr_en(ovr_en), .in_valid(in_valid),
    .in_data(in_data), .ovr_thr(ovr_thr), .ovr_hold(ovr_hold),
    .pin_mode(pin_mode), .sdo_in(sdo_in), .ovr_flag(ovr_flag),
    .pin_out(pin_out)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit over_of(input int v, input int t);
    int m;
    m = (v < 0) ? -v : v;
    return m > t;
  endfunction

  // expected flag at step k from R1..R5: an over sample within [k-8-H, k-8]
  function automatic bit exp_at(input int k, input int n);
    int h;
    int t;
    h = int'(ovr_hold);
    t = int'(ovr_thr);
    for (int i = k - LAT - h; i <= k - LAT; i++)
      if (i >= 0 && i < n && vld[i] && over_of(smp[i], t)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic clear_pat();
    for (int i = 0; i < 64; i++) begin
      smp[i] = 0;
      vld[i] = 1'b0;
    end
  endtask

  // drives n pattern steps then quiet steps; obs[k] is the flag seen before driving step k
  task automatic play(input int n, input string req);
    int total;
    total = n + 32;
    idle(30);
    for (int k = 0; k < total; k++) begin
      @(negedge clk);
      obs[k] = ovr_flag;
      in_valid = (k < n) ? vld[k] : 1'b0;
      in_data  = (k < n) ? SW'(smp[k]) : '0;
    end
    for (int k = 0; k < total; k++)
      check(obs[k] == exp_at(k, n), req, obs[k], exp_at(k, n));
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check(ovr_flag == 1'b0, "R7 reset flag", ovr_flag, 0);
    pin_mode = 1'b0;
    sdo_in = 1'b1;
    #1;
    check(pin_out == 1'b1, "R8 serial after reset", pin_out, 1);
    pin_mode = 1'b1;
    sdo_in = 1'b0;
  endtask

  task automatic t_threshold();
    ovr_thr = SW'(100);
    ovr_hold = '0;
    clear_pat();
    smp[0] = 100;  vld[0] = 1;
    smp[2] = -100; vld[2] = 1;
    smp[4] = 101;  vld[4] = 1;
    smp[6] = -101; vld[6] = 1;
    smp[8] = 5;    vld[8] = 1;
    play(10, "R1 threshold pattern");
    check(obs[11] == 1'b0, "R2 not early", obs[11], 0);
    check(obs[12] == 1'b1, "R2 latency 8", obs[12], 1);
    check(obs[8] == 1'b0, "R1 equal is in range", obs[8], 0);
  endtask

  task automatic t_hold();
    int hs [3] = '{0, 5, 15};
    foreach (hs[j]) begin
      ovr_hold = HW'(hs[j]);
      clear_pat();
      smp[0] = 3000; vld[0] = 1;
      play(1, "R3 hold pattern");
      check(obs[LAT + hs[j]] == 1'b1, "R3 last held cycle", obs[LAT + hs[j]], 1);
      check(obs[LAT + hs[j] + 1] == 1'b0, "R3 release", obs[LAT + hs[j] + 1], 0);
    end
  endtask

  task automatic t_restart();
    ovr_hold = HW'(6);
    clear_pat();
    smp[0] = 500;  vld[0] = 1;
    smp[4] = -500; vld[4] = 1;
    play(5, "R4 restart pattern");
    for (int k = 8; k <= 18; k++)
      check(obs[k] == 1'b1, "R4 no gap", obs[k], 1);
    check(obs[19] == 1'b0, "R4 release after restart", obs[19], 0);
  endtask

  task automatic t_valid();
    ovr_hold = HW'(2);
    clear_pat();
    for (int i = 0; i < 6; i++) begin
      smp[i] = 8000;
      vld[i] = 1'b0;
    end
    smp[3] = 90; vld[3] = 1;
    play(6, "R5 invalid ignored");
    for (int k = 0; k < 38; k++)
      check(obs[k] == 1'b0, "R5 flag stays low", obs[k], 0);
  endtask

  task automatic t_extremes();
    ovr_hold = '0;
    ovr_thr = SW'(8191);
    clear_pat();
    smp[0] = -8192; vld[0] = 1;
    smp[3] = 8191;  vld[3] = 1;
    play(4, "R1 extreme codes");
    check(obs[8] == 1'b1, "R1 most negative over", obs[8], 1);
    check(obs[11] == 1'b0, "R1 max positive in range", obs[11], 0);
    ovr_thr = SW'(8192);
    clear_pat();
    smp[0] = -8192; vld[0] = 1;
    play(1, "R1 most negative equal");
    check(obs[8] == 1'b0, "R1 equal magnitude in range", obs[8], 0);
  endtask

  // ctl: 0 = enable drop at steps a..b, 1 = reset at step a
  task automatic ctl_run(input bit use_rst, input int nover, input int a, input int b,
                         input string req, input int hi_step);
    ovr_thr = SW'(100);
    ovr_hold = '0;
    idle(30);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      obs[k] = ovr_flag;
      if (use_rst) rst = (k == a);
      else         ovr_en = !(k >= a && k <= b);
      in_valid = (k < nover);
      in_data = SW'(500);
    end
    in_valid = 1'b0;
    rst = 1'b0;
    ovr_en = 1'b1;
    if (hi_step >= 0)
      check(obs[hi_step] == 1'b1, req, obs[hi_step], 1);
    for (int k = a + 1; k < 40; k++)
      check(obs[k] == 1'b0, req, obs[k], 0);
  endtask

  task automatic t_enable();
    ctl_run(1'b0, 10, 12, 13, "R6 disable mid flag", 12);
    ctl_run(1'b0, 2, 3, 3, "R6 pipeline discarded", -1);
  endtask

  task automatic t_reset_mid();
    ctl_run(1'b1, 10, 12, 12, "R7 reset mid flag", 12);
    ctl_run(1'b1, 2, 3, 3, "R7 reset clears pipeline", -1);
  endtask

  task automatic t_pin();
    ovr_thr = SW'(100);
    ovr_hold = '0;
    idle(30);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      in_valid = (k == 0);
      in_data = SW'(700);
      if (k == 8) begin
        pin_mode = 1'b1;
        #1;
        check(pin_out == 1'b1, "R8 pin shows flag high", pin_out, 1);
        pin_mode = 1'b0;
        sdo_in = 1'b0;
        #1;
        check(pin_out == 1'b0, "R8 pin shows serial 0", pin_out, 0);
        sdo_in = 1'b1;
        #1;
        check(pin_out == 1'b1, "R8 pin shows serial 1", pin_out, 1);
      end
      if (k == 10) begin
        pin_mode = 1'b1;
        #1;
        check(pin_out == 1'b0, "R8 pin shows flag low", pin_out, 0);
      end
    end
    in_valid = 1'b0;
    sdo_in = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_threshold();
    t_hold();
    t_restart();
    t_valid();
    t_extremes();
    t_enable();
    t_reset_mid();
    t_pin();
    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #2000000;
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule